// File: doc/BRIEF.md
# Serial Real-Time-Clock Slave

This block is the device end of a three-wire link to a real-time-clock chip. A processor drives the link by writing bits of a control register: a chip-enable bit, a serial clock bit and a data-in bit. The block returns one data-out bit, which goes back into the readable image of that register. All inputs are sampled on the system clock. A serial clock bit is recognised only when the sampled clock goes from high to low while chip-enable is high.

Each transaction is a 16-bit frame. The first eight bits form a command byte and the last eight bits form a value byte, both sent most significant bit first. The command's numeric range selects the action. It can read one of 32 bytes of non-volatile RAM, write one of those bytes, read the status byte, read the fixed control byte, or read a BCD time register. The time registers are taken from an external counter. One command acknowledges a fault: it clears two status flags and sends a pulse that tells the interrupt logic to clear its matching pending bit.

Top module: `rtc_serial_slave`

## Requirements
- R1: After synchronous active-low reset, `sdo` and `fault_clr` are 0, the status byte is 0x90, and each RAM byte i holds bits [8i+7:8i] of the `NV_INIT` parameter.
- R2: Bits are taken only on a falling edge of `sclk` (high in the previous cycle, low in this one) while `ce` is high. Rising edges, a static `sclk`, changes of `sdi` alone, and any edges while `ce` is low shift nothing.
- R3: Any cycle with `ce` low aborts the frame, clears the partial command and value, and drives `sdo` to 0. The next frame starts again at its first command bit, and an aborted write changes no RAM byte.
- R4: For commands 0x00-0x1F, the 9th to 16th falling edges each present on `sdo` the next bit of RAM[command], most significant first. `sdo` changes in the cycle after the sampling clock edge that sees the falling edge.
- R5: Command 0x30 returns the status byte and command 0x31 returns the control byte (`CTRL_VALUE`), timed as in R4.
- R6: Commands 0x20, 0x21, 0x22, 0x24, 0x25 and 0x26 return the seconds, minutes, hours, day, month and year inputs. Every other command from 0x20 to 0x2F returns 0x00. The time inputs are captured at the 8th falling edge, so later changes within the frame have no effect on the read.
- R7: On the 16th falling edge, commands 0x80-0x9F store the value byte into RAM[command - 0x80].
- R8: On the 16th falling edge, command 0xB1 with value bit 2 set clears status bits 4 and 3 (mask 0x18) and pulses `fault_clr` high for exactly one cycle. With value bit 2 clear, the command does nothing.
- R9: After the 16th falling edge, further falling edges are ignored until `ce` goes low: no RAM write repeats, and `sdo` holds its value.
- R10: Commands that select no readable register (0x32-0xFF) drive `sdo` to 0 throughout the frame, and `sdo` is also 0 during the first eight bits of every frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce | input | 1 | Chip-enable bit from the control register |
| sclk | input | 1 | Serial clock bit from the control register |
| sdi | input | 1 | Serial data-in bit from the control register |
| bcd_sec | input | 8 | Seconds from the external counter, BCD |
| bcd_min | input | 8 | Minutes, BCD |
| bcd_hour | input | 8 | Hours, BCD |
| bcd_day | input | 8 | Day of month, BCD |
| bcd_mon | input | 8 | Month, BCD |
| bcd_year | input | 8 | Two-digit year, BCD |
| sdo | output | 1 | Serial data-out bit returned to the register image |
| fault_clr | output | 1 | One-cycle request to clear the interrupt-status fault bit |

## Verification
The assertions check the following on every cycle:
- the reset values of the outputs;
- that `sdo` is forced low when chip-enable drops;
- that `sdo` does not move without a qualified falling edge;
- that `fault_clr` lasts one cycle and follows a real falling edge.

Only the bench scenarios can show the rest. These are:
- the value of each returned byte;
- RAM writes reaching the right address;
- frames that are aborted;
- the capture point of the time inputs;
- the status flags being cleared.

For these, a behavioural model of the frame protocol is run alongside the design and compared on every clock.

// File: rtl/rtc_pkg.sv
// Package: shared constants and command decode for the serial RTC slave.
// Assumes an 8-bit command and a 32-byte RAM addressed by command[4:0].
package rtc_pkg;

    localparam int CMD_W      = 8;
    localparam int FRAME_BITS = 2 * CMD_W;
    localparam int NV_AW      = 5;
    localparam int NV_BYTES   = 1 << NV_AW;

    localparam logic [CMD_W-1:0] CMD_STATUS    = 8'h30;
    localparam logic [CMD_W-1:0] CMD_CONTROL   = 8'h31;
    localparam logic [CMD_W-1:0] CMD_FAULT_ACK = 8'hB1;
    localparam int               FAULT_ACK_BIT = 2;
    localparam logic [CMD_W-1:0] FAULT_FLAGS   = 8'h18;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_RAM,
        SRC_STAT,
        SRC_CTRL,
        SRC_TIME
    } rd_src_e;

    // Map a command byte onto the register it reads.
    function automatic rd_src_e classify(input logic [CMD_W-1:0] c);
        rd_src_e s;
        if (c[CMD_W-1:NV_AW] == '0)  s = SRC_RAM;
        else if (c[7:4] == 4'h2)     s = SRC_TIME;
        else if (c == CMD_STATUS)    s = SRC_STAT;
        else if (c == CMD_CONTROL)   s = SRC_CTRL;
        else                         s = SRC_NONE;
        return s;
    endfunction

    // True for commands that store the value byte into RAM.
    function automatic logic is_ram_write(input logic [CMD_W-1:0] c);
        return c[CMD_W-1:NV_AW] == 3'b100;
    endfunction

endpackage

// File: rtl/rtc_frame_ctl.sv
// Module: frame sequencer. Detects qualified falling serial-clock edges,
// counts frame phases (idle, 0..FRAME_BITS) and shifts command and value.
// Assumes all inputs are synchronous to clk; ce low aborts the frame.
module rtc_frame_ctl
    import rtc_pkg::*;
#(
    parameter int FB = FRAME_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             sclk,
    input  logic             sdi,
    output logic             shift_stb,
    output logic             cmd_stb,
    output logic             last_stb,
    output logic             second_half,
    output logic [CMD_W-1:0] cmd_q,
    output logic [CMD_W-1:0] cmd_next,
    output logic [CMD_W-1:0] val_next
);
    localparam int PW   = $clog2(FB + 1);
    localparam int HALF = FB / 2;

    logic             sclk_q;
    logic             idle;
    logic [PW-1:0]    ph;
    logic [PW-1:0]    eff_ph;
    logic [CMD_W-1:0] val_q;
    logic             fall;

    // Purpose: phase seen by this edge; idle counts as phase zero.
    always_comb begin
        eff_ph      = idle ? '0 : ph;
        fall        = ce & sclk_q & ~sclk;
        shift_stb   = fall & (eff_ph < PW'(FB));
        second_half = eff_ph >= PW'(HALF);
        cmd_stb     = shift_stb & (eff_ph == PW'(HALF - 1));
        last_stb    = shift_stb & (eff_ph == PW'(FB - 1));
        cmd_next    = {cmd_q[CMD_W-2:0], sdi};
        val_next    = {val_q[CMD_W-2:0], sdi};
    end

    // Purpose: remember last sampled serial clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    // Purpose: advance the phase and shift the command or value byte.
    always_ff @(posedge clk) begin
        if (!rst_n || !ce) begin
            idle  <= 1'b1;
            ph    <= '0;
            cmd_q <= '0;
            val_q <= '0;
        end else begin
            idle <= 1'b0;
            ph   <= shift_stb ? eff_ph + PW'(1) : eff_ph;
            if (shift_stb && !second_half) cmd_q <= cmd_next;
            if (shift_stb && second_half)  val_q <= val_next;
        end
    end

endmodule

// File: rtl/rtc_nvram.sv
// Module: byte-wide register file standing in for battery-backed RAM.
// Assumes one write port and one combinational read port; reset loads
// each byte from the INIT parameter.
module rtc_nvram
    import rtc_pkg::*;
#(
    parameter int                 BYTES = NV_BYTES,
    parameter logic [BYTES*8-1:0] INIT  = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(BYTES)-1:0] waddr,
    input  logic [7:0]               wdata,
    input  logic [$clog2(BYTES)-1:0] raddr,
    output logic [7:0]               rdata
);
    logic [7:0] mem [BYTES];

    for (genvar i = 0; i < BYTES; i++) begin : g_byte
        // Purpose: hold one byte, reloaded from INIT on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)                         mem[i] <= INIT[i*8 +: 8];
            else if (we && waddr == i[$clog2(BYTES)-1:0]) mem[i] <= wdata;
        end
    end

    // Purpose: asynchronous read of the addressed byte.
    always_comb rdata = mem[raddr];

endmodule

// File: rtl/rtc_read_sel.sv
// Module: picks the byte a read command returns. Unlisted time codes and
// non-readable commands yield zero. Purely combinational.
module rtc_read_sel
    import rtc_pkg::*;
#(
    parameter logic [7:0] CTRL_VALUE = 8'h00
) (
    input  logic [CMD_W-1:0] cmd,
    input  logic [7:0]       ram_byte,
    input  logic [7:0]       status,
    input  logic [7:0]       t_sec,
    input  logic [7:0]       t_min,
    input  logic [7:0]       t_hour,
    input  logic [7:0]       t_day,
    input  logic [7:0]       t_mon,
    input  logic [7:0]       t_year,
    output logic [7:0]       rd_byte
);
    logic [7:0] time_byte;

    // Purpose: choose a BCD time field from the low command nibble.
    always_comb begin
        unique case (cmd[3:0])
            4'h0:    time_byte = t_sec;
            4'h1:    time_byte = t_min;
            4'h2:    time_byte = t_hour;
            4'h4:    time_byte = t_day;
            4'h5:    time_byte = t_mon;
            4'h6:    time_byte = t_year;
            default: time_byte = 8'h00;
        endcase
    end

    // Purpose: route the selected source to the read byte.
    always_comb begin
        unique case (classify(cmd))
            SRC_RAM:  rd_byte = ram_byte;
            SRC_TIME: rd_byte = time_byte;
            SRC_STAT: rd_byte = status;
            SRC_CTRL: rd_byte = CTRL_VALUE;
            default:  rd_byte = 8'h00;
        endcase
    end

endmodule

// File: rtl/rtc_serial_slave.sv
// Module: top of the serial RTC slave. Ties the frame sequencer, RAM and
// read selector together; owns the status byte, the output shifter, sdo
// and the fault-clear pulse. Assumes synchronous inputs on clk.
module rtc_serial_slave
    import rtc_pkg::*;
#(
    parameter logic [NV_BYTES*8-1:0] NV_INIT     = '0,
    parameter logic [7:0]            STATUS_INIT = 8'h90,
    parameter logic [7:0]            CTRL_VALUE  = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce,
    input  logic       sclk,
    input  logic       sdi,
    input  logic [7:0] bcd_sec,
    input  logic [7:0] bcd_min,
    input  logic [7:0] bcd_hour,
    input  logic [7:0] bcd_day,
    input  logic [7:0] bcd_mon,
    input  logic [7:0] bcd_year,
    output logic       sdo,
    output logic       fault_clr
);
    logic             shift_stb, cmd_stb, last_stb, second_half;
    logic [CMD_W-1:0] cmd_q, cmd_next, val_next;
    logic [7:0]       ram_rd, sel_byte, status_q, out_sh;
    logic             ram_we, ack_hit;

    rtc_frame_ctl #(.FB(FRAME_BITS)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .ce          (ce),
        .sclk        (sclk),
        .sdi         (sdi),
        .shift_stb   (shift_stb),
        .cmd_stb     (cmd_stb),
        .last_stb    (last_stb),
        .second_half (second_half),
        .cmd_q       (cmd_q),
        .cmd_next    (cmd_next),
        .val_next    (val_next)
    );

    // Purpose: decode the end-of-frame write and fault acknowledge.
    always_comb begin
        ram_we  = last_stb & is_ram_write(cmd_q);
        ack_hit = last_stb & (cmd_q == CMD_FAULT_ACK) & val_next[FAULT_ACK_BIT];
    end

    rtc_nvram #(.BYTES(NV_BYTES), .INIT(NV_INIT)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .waddr (cmd_q[NV_AW-1:0]),
        .wdata (val_next),
        .raddr (cmd_next[NV_AW-1:0]),
        .rdata (ram_rd)
    );

    rtc_read_sel #(.CTRL_VALUE(CTRL_VALUE)) u_sel (
        .cmd      (cmd_next),
        .ram_byte (ram_rd),
        .status   (status_q),
        .t_sec    (bcd_sec),
        .t_min    (bcd_min),
        .t_hour   (bcd_hour),
        .t_day    (bcd_day),
        .t_mon    (bcd_mon),
        .t_year   (bcd_year),
        .rd_byte  (sel_byte)
    );

    // Purpose: status byte with fault flags cleared on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)       status_q <= STATUS_INIT;
        else if (ack_hit) status_q <= status_q & ~FAULT_FLAGS;
    end

    // Purpose: one-cycle request to clear the interrupt fault bit.
    always_ff @(posedge clk) begin
        if (!rst_n) fault_clr <= 1'b0;
        else        fault_clr <= ack_hit;
    end

    // Purpose: capture the read byte at command completion, then shift it.
    always_ff @(posedge clk) begin
        if (!rst_n)                        out_sh <= '0;
        else if (cmd_stb)                  out_sh <= sel_byte;
        else if (shift_stb && second_half) out_sh <= {out_sh[6:0], 1'b0};
    end

    // Purpose: drive data-out, low outside the second half of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !ce) sdo <= 1'b0;
        else if (shift_stb) sdo <= second_half ? out_sh[7] : 1'b0;
    end

endmodule

// File: rtl/rtc_serial_slave_chk.sv
// Module: protocol checker bound onto rtc_serial_slave; observes ports only.
module rtc_serial_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic ce,
    input logic sclk,
    input logic sdo,
    input logic fault_clr
);
    // R1
    reset_outputs_chk: assert property (@(posedge clk)
        !rst_n |=> (!sdo && !fault_clr));

    // R3
    ce_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> !sdo);

    // R2
    no_edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !($past(sclk) && !sclk)) |=> $stable(sdo));

    // R8
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_clr |=> !fault_clr);

    // R8
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_clr) |-> ($past(ce) && !$past(sclk) && $past(sclk, 2)));

endmodule

bind rtc_serial_slave rtc_serial_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce        (ce),
    .sclk      (sclk),
    .sdo       (sdo),
    .fault_clr (fault_clr)
);

// File: tb/sim_rtc_serial_slave.sv
// Bench: drives serial frames, runs a behavioural protocol model next to the
// design, compares sdo and fault_clr every clock, and checks read-back bytes.
module sim_rtc_serial_slave;

    localparam logic [255:0] BENCH_INIT =
        256'h00112233445566778899AABBCCDDEEFF0F1E2D3C4B5A69788796A5B4C3D2E1F0;
    localparam logic [7:0] CTRL_B = 8'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce = 1'b0, sclk = 1'b0, sdi = 1'b0;
    logic [7:0] t_sec = 8'h00, t_min = 8'h00, t_hour = 8'h00;
    logic [7:0] t_day = 8'h01, t_mon = 8'h01, t_year = 8'h00;
    logic sdo, fault_clr;

    int n_chk = 0, n_err = 0;
    bit fc_seen = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rtc_serial_slave #(.NV_INIT(BENCH_INIT), .STATUS_INIT(8'h90), .CTRL_VALUE(CTRL_B)) u0 (
        .clk(clk), .rst_n(rst_n), .ce(ce), .sclk(sclk), .sdi(sdi),
        .bcd_sec(t_sec), .bcd_min(t_min), .bcd_hour(t_hour),
        .bcd_day(t_day), .bcd_mon(t_mon), .bcd_year(t_year),
        .sdo(sdo), .fault_clr(fault_clr)
    );

    // ---------------- behavioural reference model ----------------
    int m_ph, m_cmd, m_val, m_byte, m_stat;
    int m_ram [32];
    bit m_prev, m_sdo, m_fc;

    function automatic int lookup(int c);
        if (c < 32)  return m_ram[c];
        if (c == 48) return m_stat;
        if (c == 49) return int'(CTRL_B);
        case (c)
            32: return int'(t_sec);
            33: return int'(t_min);
            34: return int'(t_hour);
            36: return int'(t_day);
            37: return int'(t_mon);
            38: return int'(t_year);
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = -1; m_cmd = 0; m_val = 0; m_byte = 0; m_stat = 'h90;
            m_prev = 0; m_sdo = 0; m_fc = 0;
            for (int i = 0; i < 32; i++) m_ram[i] = int'(BENCH_INIT[i*8 +: 8]);
        end else begin
            bit fall;
            fall = m_prev && !sclk && ce;
            m_prev = sclk;
            m_fc = 0;
            if (!ce) begin
                m_ph = -1; m_cmd = 0; m_val = 0; m_sdo = 0;
            end else begin
                if (m_ph == -1) m_ph = 0;
                if (fall && m_ph < 16) begin
                    if (m_ph < 8) begin
                        m_cmd = ((m_cmd << 1) | int'(sdi)) & 255;
                        m_sdo = 0;
                        if (m_ph == 7) m_byte = lookup(m_cmd);
                    end else begin
                        m_val = ((m_val << 1) | int'(sdi)) & 255;
                        m_sdo = ((m_byte >> (15 - m_ph)) & 1) != 0;
                    end
                    m_ph++;
                    if (m_ph == 16) begin
                        if (m_cmd >= 'h80 && m_cmd <= 'h9F) m_ram[m_cmd - 'h80] = m_val;
                        if (m_cmd == 'hB1 && (m_val & 4) != 0) begin
                            m_stat = m_stat & ~'h18;
                            m_fc = 1;
                        end
                    end
                end
            end
        end
    end

    // ---------------- checking ----------------
    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-clock comparison against the model (R2 R4 R8 R10 protocol timing).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (fault_clr) fc_seen = 1;
            n_chk++;
            if (sdo !== m_sdo || fault_clr !== m_fc) begin
                n_err++;
                $display("FAIL R4 model compare: actual sdo=%0b fc=%0b expected sdo=%0b fc=%0b",
                         sdo, fault_clr, m_sdo, m_fc);
            end
        end
    end

    task automatic shift_bits(input logic [15:0] word, input int nbits, input bit bump,
                              output logic [7:0] rd);
        rd = 8'h00;
        ce = 1'b1;
        for (int i = 0; i < nbits; i++) begin
            if (bump && i == 8) begin
                t_sec = 8'h11; t_min = 8'h22; t_hour = 8'h03;
                t_day = 8'h04; t_mon = 8'h05; t_year = 8'h06;
            end
            sdi = word[15-i];
            sclk = 1'b1;
            @(negedge clk);
            sclk = 1'b0;
            @(negedge clk);
            if (i >= 8) rd = {rd[6:0], sdo};
        end
    endtask

    task automatic end_frame();
        ce = 1'b0; sclk = 1'b0; sdi = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic read_reg(input logic [7:0] cmd, output logic [7:0] rd);
        shift_bits({cmd, 8'h00}, 16, 1'b0, rd);
        end_frame();
    endtask

    task automatic write_reg(input logic [7:0] cmd, input logic [7:0] val);
        logic [7:0] dummy;
        shift_bits({cmd, val}, 16, 1'b0, dummy);
        end_frame();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        done = 1;
        summary();
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset outputs and RAM contents
        check8("R1 sdo after reset", {7'd0, sdo}, 8'h00);
        check8("R1 fault_clr after reset", {7'd0, fault_clr}, 8'h00);
        read_reg(8'h00, rd); check8("R1 R4 ram[0]", rd, BENCH_INIT[0 +: 8]);
        read_reg(8'h1F, rd); check8("R1 R4 ram[31]", rd, BENCH_INIT[31*8 +: 8]);
        read_reg(8'h0A, rd); check8("R4 ram[10]", rd, BENCH_INIT[10*8 +: 8]);

        // R2: edges with ce low and sdi changes alone shift nothing
        ce = 1'b0; sdi = 1'b1;
        for (int k = 0; k < 4; k++) begin
            sclk = 1'b1; @(negedge clk); sclk = 1'b0; @(negedge clk);
        end
        ce = 1'b1; sclk = 1'b1;
        for (int k = 0; k < 6; k++) begin
            sdi = ~sdi; @(negedge clk);
        end
        shift_bits({8'h07, 8'h00}, 16, 1'b0, rd);
        end_frame();
        check8("R2 no stray shift ram[7]", rd, BENCH_INIT[7*8 +: 8]);

        // R3: aborted command and aborted write
        shift_bits({8'h1F, 8'h00}, 5, 1'b0, rd);
        end_frame();
        read_reg(8'h02, rd); check8("R3 fresh frame after abort", rd, BENCH_INIT[2*8 +: 8]);
        shift_bits({8'h84, 8'hFF}, 12, 1'b0, rd);
        end_frame();
        read_reg(8'h04, rd); check8("R3 aborted write leaves ram[4]", rd, BENCH_INIT[4*8 +: 8]);

        // R7: RAM writes
        write_reg(8'h83, 8'hA5);
        read_reg(8'h03, rd); check8("R7 write ram[3]", rd, 8'hA5);
        write_reg(8'h9F, 8'h3C);
        read_reg(8'h1F, rd); check8("R7 write ram[31]", rd, 8'h3C);

        // R9: edges after the 16th are ignored
        shift_bits({8'h86, 8'h3C}, 16, 1'b0, rd);
        shift_bits({8'h86, 8'hFF}, 16, 1'b0, rd);
        check8("R9 sdo holds after frame end", rd, 8'h00);
        end_frame();
        read_reg(8'h06, rd); check8("R9 single write ram[6]", rd, 8'h3C);

        // R5: status and control
        read_reg(8'h30, rd); check8("R5 status", rd, 8'h90);
        read_reg(8'h31, rd); check8("R5 control", rd, CTRL_B);

        // R8: fault acknowledge
        fc_seen = 0;
        write_reg(8'hB1, 8'hFB);
        check8("R8 no pulse without bit2", {7'd0, fc_seen}, 8'h00);
        read_reg(8'h30, rd); check8("R8 status kept", rd, 8'h90);
        fc_seen = 0;
        write_reg(8'hB1, 8'h04);
        check8("R8 pulse with bit2", {7'd0, fc_seen}, 8'h01);
        read_reg(8'h30, rd); check8("R8 status cleared", rd, 8'h80);

        // R6: time registers
        t_sec = 8'h59; t_min = 8'h47; t_hour = 8'h23;
        t_day = 8'h31; t_mon = 8'h12; t_year = 8'h99;
        read_reg(8'h20, rd); check8("R6 seconds", rd, 8'h59);
        read_reg(8'h21, rd); check8("R6 minutes", rd, 8'h47);
        read_reg(8'h22, rd); check8("R6 hours", rd, 8'h23);
        read_reg(8'h24, rd); check8("R6 day", rd, 8'h31);
        read_reg(8'h25, rd); check8("R6 month", rd, 8'h12);
        read_reg(8'h26, rd); check8("R6 year", rd, 8'h99);
        read_reg(8'h23, rd); check8("R6 unlisted 0x23", rd, 8'h00);
        read_reg(8'h2F, rd); check8("R6 unlisted 0x2F", rd, 8'h00);
        shift_bits({8'h21, 8'h00}, 16, 1'b1, rd);
        end_frame();
        check8("R6 captured at command end", rd, 8'h47);
        read_reg(8'h21, rd); check8("R6 new minutes", rd, 8'h22);

        // R10: non-readable commands return zero
        read_reg(8'h40, rd); check8("R10 cmd 0x40", rd, 8'h00);
        read_reg(8'hFF, rd); check8("R10 cmd 0xFF", rd, 8'h00);
        read_reg(8'h32, rd); check8("R10 cmd 0x32", rd, 8'h00);

        repeat (4) @(negedge clk);
        done = 1;
        summary();
    end

endmodule